// File: doc/BRIEF.md
# Direct-Map Window Address Translator

This block is the first stage of virtual-to-physical translation in a processor memory pipeline. Each cycle it may accept one request carrying a 64-bit virtual address, an access kind, the two paging-mode bits, a user/kernel flag and a 32/64-bit mode flag. It resolves the request to one of four routes:

- **direct:** unpaged passthrough.
- **window:** a hit in one of several prioritised direct-map segment windows, each configured by a 64-bit word.
- **fault:** a non-canonical address.
- **TLB:** a hand-off to the page-table lookup that follows this stage.

Independently, it turns a failure code reported back by that TLB stage into a 6-bit exception cause. A miss also raises a refill flag. All outputs are registered, one cycle after the inputs are sampled.

Top module: `dmw_xlat_top`

## Requirements
- R1: Synchronous active-high reset clears `out_valid`, `out_route`, `out_paddr`, `out_perm`, `exc_valid`, `exc_code` and `exc_refill` to zero. With `req_valid` low, the next cycle shows `out_valid`=0 and `out_route`=0.
- R2: The direct route applies when `req_da`=1 and `req_pg`=0. One cycle later the outputs are:
  - `out_route`=4'b0001;
  - `out_paddr` equals the virtual address with bits at and above PA_W cleared;
  - `out_perm`=3'b111 (bit2 read, bit1 write, bit0 execute).
  No window is consulted.
- R3: Window k is enabled for kernel requests by config bit 0 and for user requests by config bit 3. It hits on segment equality:
  - in 64-bit mode, config[63:60] against vaddr[63:60];
  - in 32-bit mode, config[31:29] against vaddr[31:29].
  A hit gives `out_route`=4'b0010.
- R4: Windows are searched in index order and the lowest-numbered hit decides the result.
- R5: The physical address of a window hit depends on the mode:
  - in 64-bit mode, vaddr[VA_W-1:0] zero-extended;
  - in 32-bit mode, {32'b0, config[27:25], vaddr[28:0]}.
- R6: A window hit gives `out_perm`=3'b111 and raises no exception.
- R7: When neither the direct route nor any window applies, the outcome depends on the mode:
  - In 64-bit mode, bits [VA_W+15:VA_W] must be all zeros or all ones. If they are not, the request takes the fault route (4'b0100) and `exc_valid` is set, with cause 8 for a fetch (`req_acc`=2) and 9 for a load (0) or store (1).
  - Otherwise the route is TLB (4'b1000), with `out_paddr`=0, `out_perm`=0 and no exception.
  - In 32-bit mode there is no canonical check.
- R8: A reported TLB failure is mapped by access kind:
  - Code 1 (miss) and code 2 (invalid entry) map to cause 1 for a load, 2 for a store and 3 for a fetch.
  - Only a miss sets `exc_refill`.
- R9: The remaining reported TLB failure codes map as follows:
  - code 3 (store to clean page) gives cause 4;
  - code 4 (read inhibit) gives cause 5;
  - code 5 (execute inhibit) gives cause 6;
  - code 6 (privilege) gives cause 7;
  - codes 0 and 7 give the address-error cause (8 fetch, 9 otherwise).
- R10: When a bad address and a TLB failure report arrive in the same cycle, the bad-address cause wins and `exc_refill` stays 0. `out_valid` equals the OR of the route bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_da | input | 1 | Direct-addressing mode bit |
| req_pg | input | 1 | Paging-enable mode bit |
| req_user | input | 1 | 1 = user privilege, 0 = kernel |
| req_is64 | input | 1 | 1 = 64-bit address mode |
| win_cfg | input | NWIN*64 | Window configuration words, window k at bits [64k+63:64k] |
| tlb_fail_valid | input | 1 | TLB stage reports a failure |
| tlb_fail_code | input | 3 | TLB failure code |
| tlb_fail_acc | input | 2 | Access kind of the failed TLB lookup |
| out_valid | output | 1 | Registered result present |
| out_route | output | 4 | One-hot route: bit0 direct, bit1 window, bit2 fault, bit3 TLB |
| out_paddr | output | 64 | Physical address for direct and window routes |
| out_perm | output | 3 | Permissions: bit2 read, bit1 write, bit0 execute |
| exc_valid | output | 1 | Exception cause valid |
| exc_code | output | 6 | Exception cause |
| exc_refill | output | 1 | TLB refill in progress (miss) |

## Verification
The embedded properties assume that `req_acc` never carries the reserved value 3. They also assume that the window configuration stays still while requests are in flight, because route and permission pairs are checked on registered outputs against the configuration of the current cycle. The stimulus sets the window words once after reset and leaves them alone. It drives only load, store and fetch kinds, and changes every input at the falling edge. The window words are chosen so that two windows share a segment under differing privilege enables, which makes priority and enable selection visible through the 32-bit segment remap.

// File: rtl/dmw_xlat_pkg.sv
package dmw_xlat_pkg;

    localparam int XLEN = 64;

    // access kinds
    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    // failure codes reported back by the TLB stage
    localparam logic [2:0] TF_NONE    = 3'd0;
    localparam logic [2:0] TF_MISS    = 3'd1;
    localparam logic [2:0] TF_INVALID = 3'd2;
    localparam logic [2:0] TF_DIRTY   = 3'd3;
    localparam logic [2:0] TF_RINH    = 3'd4;
    localparam logic [2:0] TF_XINH    = 3'd5;
    localparam logic [2:0] TF_PRIV    = 3'd6;

    // exception causes
    localparam logic [5:0] CA_LOAD_INV  = 6'd1;
    localparam logic [5:0] CA_STORE_INV = 6'd2;
    localparam logic [5:0] CA_FETCH_INV = 6'd3;
    localparam logic [5:0] CA_MODIFY    = 6'd4;
    localparam logic [5:0] CA_READ_INH  = 6'd5;
    localparam logic [5:0] CA_EXEC_INH  = 6'd6;
    localparam logic [5:0] CA_PRIV      = 6'd7;
    localparam logic [5:0] CA_ADDR_F    = 6'd8;
    localparam logic [5:0] CA_ADDR_M    = 6'd9;

    // route bit positions
    localparam int RT_DIRECT = 0;
    localparam int RT_WINDOW = 1;
    localparam int RT_FAULT  = 2;
    localparam int RT_TLB    = 3;

    // window configuration fields
    localparam int WC_KERN_EN   = 0;
    localparam int WC_USER_EN   = 3;
    localparam int SEG64_LSB    = 60;
    localparam int SEG32_LSB    = 29;
    localparam int SEG32_W      = 3;
    localparam int PSEG32_LSB   = 25;

    localparam logic [2:0] PERM_RWX = 3'b111;

    typedef struct packed {
        logic [3:0]      route;
        logic [XLEN-1:0] paddr;
        logic [2:0]      perm;
    } xlat_res_t;

    typedef struct packed {
        logic       valid;
        logic [5:0] code;
        logic       refill;
    } exc_res_t;

    function automatic logic [5:0] page_inv_cause(input logic [1:0] acc);
        if (acc == ACC_FETCH)      return CA_FETCH_INV;
        else if (acc == ACC_STORE) return CA_STORE_INV;
        else                       return CA_LOAD_INV;
    endfunction

    function automatic logic [5:0] addr_err_cause(input logic [1:0] acc);
        return (acc == ACC_FETCH) ? CA_ADDR_F : CA_ADDR_M;
    endfunction

endpackage

// File: rtl/dmw_win_match.sv
module dmw_win_match
    import dmw_xlat_pkg::*;
#(
    parameter int VA_W = 48
) (
    input  logic [XLEN-1:0] cfg,
    input  logic [XLEN-1:0] vaddr,
    input  logic            user,
    input  logic            is64,
    output logic            hit,
    output logic [XLEN-1:0] paddr
);
    localparam int SEG64_W = XLEN - SEG64_LSB;

    logic enabled;
    logic seg_eq;

    always_comb begin
        enabled = user ? cfg[WC_USER_EN] : cfg[WC_KERN_EN];
        if (is64)
            seg_eq = (cfg[XLEN-1 -: SEG64_W] == vaddr[XLEN-1 -: SEG64_W]);
        else
            seg_eq = (cfg[SEG32_LSB +: SEG32_W] == vaddr[SEG32_LSB +: SEG32_W]);
        hit = enabled && seg_eq;

        paddr = '0;
        if (is64) begin
            paddr[VA_W-1:0] = vaddr[VA_W-1:0];
        end else begin
            paddr[SEG32_LSB-1:0]           = vaddr[SEG32_LSB-1:0];
            paddr[SEG32_LSB +: SEG32_W]    = cfg[PSEG32_LSB +: SEG32_W];
        end
    end
endmodule

// File: rtl/dmw_canon_chk.sv
module dmw_canon_chk
    import dmw_xlat_pkg::*;
#(
    parameter int VA_W = 48
) (
    input  logic [XLEN-1:0] vaddr,
    output logic            ok
);
    localparam int EXT_W = 16;

    logic [EXT_W-1:0] ext;

    always_comb begin
        ext = vaddr[VA_W +: EXT_W];
        ok  = (&ext) || !(|ext);
    end
endmodule

// File: rtl/dmw_exc_map.sv
module dmw_exc_map
    import dmw_xlat_pkg::*;
(
    input  logic       bad_valid,
    input  logic [1:0] bad_acc,
    input  logic       tf_valid,
    input  logic [2:0] tf_code,
    input  logic [1:0] tf_acc,
    output exc_res_t   res
);
    always_comb begin
        res = '0;
        if (bad_valid) begin
            res.valid = 1'b1;
            res.code  = addr_err_cause(bad_acc);
        end else if (tf_valid) begin
            res.valid = 1'b1;
            case (tf_code)
                TF_MISS: begin
                    res.code   = page_inv_cause(tf_acc);
                    res.refill = 1'b1;
                end
                TF_INVALID: res.code = page_inv_cause(tf_acc);
                TF_DIRTY:   res.code = CA_MODIFY;
                TF_RINH:    res.code = CA_READ_INH;
                TF_XINH:    res.code = CA_EXEC_INH;
                TF_PRIV:    res.code = CA_PRIV;
                default:    res.code = addr_err_cause(tf_acc);
            endcase
        end
    end
endmodule

// File: rtl/dmw_xlat_top.sv
module dmw_xlat_top
    import dmw_xlat_pkg::*;
#(
    parameter int VA_W = 48,
    parameter int PA_W = 48,
    parameter int NWIN = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [63:0]          req_vaddr,
    input  logic [1:0]           req_acc,
    input  logic                 req_da,
    input  logic                 req_pg,
    input  logic                 req_user,
    input  logic                 req_is64,
    input  logic [NWIN*64-1:0]   win_cfg,
    input  logic                 tlb_fail_valid,
    input  logic [2:0]           tlb_fail_code,
    input  logic [1:0]           tlb_fail_acc,
    output logic                 out_valid,
    output logic [3:0]           out_route,
    output logic [63:0]          out_paddr,
    output logic [2:0]           out_perm,
    output logic                 exc_valid,
    output logic [5:0]           exc_code,
    output logic                 exc_refill
);
    localparam logic [XLEN-1:0] PA_MASK = (PA_W >= XLEN) ? '1 : ((64'd1 << PA_W) - 64'd1);

    logic [NWIN-1:0] win_hit;
    logic [XLEN-1:0] win_pa [NWIN];
    logic            canon_ok;
    logic            direct;
    logic            any_hit;
    logic [XLEN-1:0] sel_pa;
    logic            bad_addr;
    xlat_res_t       nxt, cur;
    exc_res_t        exc_nxt, exc_cur;
    logic            valid_q;

    for (genvar k = 0; k < NWIN; k++) begin : g_win
        dmw_win_match #(.VA_W(VA_W)) u_match (
            .cfg   (win_cfg[k*64 +: 64]),
            .vaddr (req_vaddr),
            .user  (req_user),
            .is64  (req_is64),
            .hit   (win_hit[k]),
            .paddr (win_pa[k])
        );
    end

    dmw_canon_chk #(.VA_W(VA_W)) u_canon (
        .vaddr (req_vaddr),
        .ok    (canon_ok)
    );

    // lowest index wins: scan downward so the last assignment is the lowest hit
    always_comb begin
        sel_pa = '0;
        for (int k = NWIN - 1; k >= 0; k--) begin
            if (win_hit[k]) sel_pa = win_pa[k];
        end
        any_hit = |win_hit;
    end

    always_comb begin
        direct   = req_da && !req_pg;
        bad_addr = req_valid && !direct && !any_hit && req_is64 && !canon_ok;
        nxt      = '0;
        if (req_valid) begin
            if (direct) begin
                nxt.route[RT_DIRECT] = 1'b1;
                nxt.paddr            = req_vaddr & PA_MASK;
                nxt.perm             = PERM_RWX;
            end else if (any_hit) begin
                nxt.route[RT_WINDOW] = 1'b1;
                nxt.paddr            = sel_pa;
                nxt.perm             = PERM_RWX;
            end else if (bad_addr) begin
                nxt.route[RT_FAULT]  = 1'b1;
            end else begin
                nxt.route[RT_TLB]    = 1'b1;
            end
        end
    end

    dmw_exc_map u_exc (
        .bad_valid (bad_addr),
        .bad_acc   (req_acc),
        .tf_valid  (tlb_fail_valid),
        .tf_code   (tlb_fail_code),
        .tf_acc    (tlb_fail_acc),
        .res       (exc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            exc_cur <= '0;
            valid_q <= 1'b0;
        end else begin
            cur     <= nxt;
            exc_cur <= exc_nxt;
            valid_q <= req_valid;
        end
    end

    assign out_valid  = valid_q;
    assign out_route  = cur.route;
    assign out_paddr  = cur.paddr;
    assign out_perm   = cur.perm;
    assign exc_valid  = exc_cur.valid;
    assign exc_code   = exc_cur.code;
    assign exc_refill = exc_cur.refill;

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_route == 4'b0 && !exc_valid && !out_valid));

    a_r10_route_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_route));

    a_r10_valid_has_route: assert property (@(posedge clk) disable iff (rst)
        out_valid == (|out_route));

    a_r2_direct_full_perm: assert property (@(posedge clk) disable iff (rst)
        out_route[RT_DIRECT] |-> (out_perm == PERM_RWX));

    a_r6_window_full_perm: assert property (@(posedge clk) disable iff (rst)
        out_route[RT_WINDOW] |-> (out_perm == PERM_RWX));

    a_r7_fault_raises_addr_err: assert property (@(posedge clk) disable iff (rst)
        out_route[RT_FAULT] |-> (exc_valid && (exc_code == CA_ADDR_F || exc_code == CA_ADDR_M)));

    a_r7_tlb_route_no_perm: assert property (@(posedge clk) disable iff (rst)
        out_route[RT_TLB] |-> (out_perm == 3'b0 && out_paddr == '0));

    a_r8_refill_is_page_inv: assert property (@(posedge clk) disable iff (rst)
        exc_refill |-> (exc_valid && exc_code >= CA_LOAD_INV && exc_code <= CA_FETCH_INV));

    a_r10_fault_beats_tlb: assert property (@(posedge clk) disable iff (rst)
        out_route[RT_FAULT] |-> !exc_refill);

endmodule

// File: tb/test_dmw_xlat_top.sv
module test_dmw_xlat_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [63:0]  req_vaddr = '0;
    logic [1:0]   req_acc = '0;
    logic         req_da = 1'b0;
    logic         req_pg = 1'b0;
    logic         req_user = 1'b0;
    logic         req_is64 = 1'b0;
    logic [255:0] win_cfg = '0;
    logic         tlb_fail_valid = 1'b0;
    logic [2:0]   tlb_fail_code = '0;
    logic [1:0]   tlb_fail_acc = '0;
    logic         out_valid;
    logic [3:0]   out_route;
    logic [63:0]  out_paddr;
    logic [2:0]   out_perm;
    logic         exc_valid;
    logic [5:0]   exc_code;
    logic         exc_refill;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dmw_xlat_top i_dmw_xlat_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_da(req_da), .req_pg(req_pg), .req_user(req_user),
        .req_is64(req_is64), .win_cfg(win_cfg), .tlb_fail_valid(tlb_fail_valid),
        .tlb_fail_code(tlb_fail_code), .tlb_fail_acc(tlb_fail_acc),
        .out_valid(out_valid), .out_route(out_route), .out_paddr(out_paddr),
        .out_perm(out_perm), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_refill(exc_refill)
    );

    typedef struct packed {
        logic        da, pg, user, is64;
        logic [1:0]  acc;
        logic [63:0] va;
        logic [3:0]  route;
        logic [63:0] pa;
        logic [2:0]  perm;
        logic        ev;
        logic [5:0]  code;
    } vec_t;

    localparam int NV = 15;
    // windows: 0 kernel seg 9 / seg32 000; 1 user seg 9 / seg32 101 -> 011;
    //          2 both seg 8 / seg32 000; 3 both seg 5 / seg32 101 -> 001
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b1,2'd0,64'h9123_4567_89AB_CDEF,4'h1,64'h0000_4567_89AB_CDEF,3'd7,1'b0,6'd0},
        '{1'b1,1'b0,1'b1,1'b0,2'd2,64'h0000_0000_A000_1234,4'h1,64'h0000_0000_A000_1234,3'd7,1'b0,6'd0},
        '{1'b0,1'b1,1'b0,1'b1,2'd0,64'h9000_1234_5678_9ABC,4'h2,64'h0000_1234_5678_9ABC,3'd7,1'b0,6'd0},
        '{1'b0,1'b1,1'b1,1'b1,2'd1,64'h9000_1234_5678_9ABC,4'h2,64'h0000_1234_5678_9ABC,3'd7,1'b0,6'd0},
        '{1'b0,1'b1,1'b1,1'b1,2'd0,64'h8000_0000_0000_0010,4'h2,64'h0000_0000_0000_0010,3'd7,1'b0,6'd0},
        '{1'b1,1'b1,1'b0,1'b1,2'd0,64'h5000_00AB_CDEF_0123,4'h2,64'h0000_00AB_CDEF_0123,3'd7,1'b0,6'd0},
        // R4: user hits window 1 first, kernel skips to window 3
        '{1'b0,1'b1,1'b1,1'b0,2'd0,64'h0000_0000_A000_1234,4'h2,64'h0000_0000_6000_1234,3'd7,1'b0,6'd0},
        '{1'b0,1'b1,1'b0,1'b0,2'd0,64'h0000_0000_A000_1234,4'h2,64'h0000_0000_2000_1234,3'd7,1'b0,6'd0},
        '{1'b0,1'b1,1'b0,1'b0,2'd1,64'h0000_0000_1000_0000,4'h2,64'h0000_0000_1000_0000,3'd7,1'b0,6'd0},
        '{1'b0,1'b1,1'b1,1'b0,2'd0,64'h0000_0000_4000_0000,4'h8,64'h0,3'd0,1'b0,6'd0},
        '{1'b0,1'b1,1'b0,1'b1,2'd0,64'h0000_7FFF_FFFF_F000,4'h8,64'h0,3'd0,1'b0,6'd0},
        '{1'b0,1'b1,1'b0,1'b1,2'd2,64'hFFFF_8000_0000_0000,4'h8,64'h0,3'd0,1'b0,6'd0},
        '{1'b0,1'b1,1'b0,1'b1,2'd2,64'h0001_0000_0000_0000,4'h4,64'h0,3'd0,1'b1,6'd8},
        '{1'b0,1'b1,1'b1,1'b1,2'd1,64'h7FFF_0000_0000_0000,4'h4,64'h0,3'd0,1'b1,6'd9},
        '{1'b0,1'b0,1'b0,1'b1,2'd0,64'h9000_0000_0000_0040,4'h2,64'h0000_0000_0000_0040,3'd7,1'b0,6'd0}
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; tlb_fail_valid = 1'b0;
        req_da = 1'b0; req_pg = 1'b0; req_user = 1'b0; req_is64 = 1'b0;
        req_acc = 2'd0; req_vaddr = '0; tlb_fail_code = '0; tlb_fail_acc = '0;
    endtask

    task automatic tlb_case(input logic [2:0] code, input logic [1:0] acc,
                            input logic [5:0] exp_code, input logic exp_ref, input string tag);
        @(negedge clk);
        idle_inputs();
        tlb_fail_valid = 1'b1; tlb_fail_code = code; tlb_fail_acc = acc;
        @(posedge clk); #1;
        chk({tag, " exc_valid"}, 64'(exc_valid), 64'd1);
        chk({tag, " exc_code"}, 64'(exc_code), 64'(exp_code));
        chk({tag, " refill"}, 64'(exc_refill), 64'(exp_ref));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 route", 64'(out_route), 64'd0);
        chk("R1 exc_valid", 64'(exc_valid), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        win_cfg = {64'h5000_0000_A200_0009, 64'h8000_0000_0000_0009,
                   64'h9000_0000_A600_0008, 64'h9000_0000_0000_0001};

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle_inputs();
            req_valid = 1'b1;
            req_da = VEC[i].da; req_pg = VEC[i].pg; req_user = VEC[i].user;
            req_is64 = VEC[i].is64; req_acc = VEC[i].acc; req_vaddr = VEC[i].va;
            @(posedge clk); #1;
            chk($sformatf("R3 v%0d route", i), 64'(out_route), 64'(VEC[i].route));
            chk($sformatf("%s v%0d paddr", VEC[i].route == 4'h1 ? "R2" : "R5", i),
                out_paddr, VEC[i].pa);
            chk($sformatf("%s v%0d perm", VEC[i].route == 4'h1 ? "R2" : "R6", i),
                64'(out_perm), 64'(VEC[i].perm));
            chk($sformatf("R7 v%0d exc", i), {57'd0, exc_valid, exc_code},
                {57'd0, VEC[i].ev, VEC[i].code});
        end

        // R8: miss and invalid by access kind
        tlb_case(3'd1, 2'd0, 6'd1, 1'b1, "R8 miss load");
        tlb_case(3'd1, 2'd1, 6'd2, 1'b1, "R8 miss store");
        tlb_case(3'd2, 2'd2, 6'd3, 1'b0, "R8 invalid fetch");
        tlb_case(3'd2, 2'd0, 6'd1, 1'b0, "R8 invalid load");
        // R9: other failures
        tlb_case(3'd3, 2'd1, 6'd4, 1'b0, "R9 dirty");
        tlb_case(3'd4, 2'd0, 6'd5, 1'b0, "R9 read inhibit");
        tlb_case(3'd5, 2'd2, 6'd6, 1'b0, "R9 exec inhibit");
        tlb_case(3'd6, 2'd0, 6'd7, 1'b0, "R9 privilege");
        tlb_case(3'd0, 2'd2, 6'd8, 1'b0, "R9 code0 fetch");
        tlb_case(3'd7, 2'd1, 6'd9, 1'b0, "R9 code7 store");

        // R10: bad address and TLB miss in the same cycle
        @(negedge clk);
        idle_inputs();
        req_valid = 1'b1; req_pg = 1'b1; req_is64 = 1'b1; req_acc = 2'd2;
        req_vaddr = 64'h1234_0000_0000_0000;
        tlb_fail_valid = 1'b1; tlb_fail_code = 3'd1; tlb_fail_acc = 2'd0;
        @(posedge clk); #1;
        chk("R10 collision code", 64'(exc_code), 64'd8);
        chk("R10 collision refill", 64'(exc_refill), 64'd0);
        chk("R10 collision route", 64'(out_route), 64'h4);

        // R1: idle request gives no valid output
        @(negedge clk);
        idle_inputs();
        @(posedge clk); #1;
        chk("R1 idle valid", 64'(out_valid), 64'd0);
        chk("R1 idle route", 64'(out_route), 64'd0);

        // R1: reset clears a pending result
        @(negedge clk);
        req_valid = 1'b1; req_da = 1'b1; req_vaddr = 64'h55;
        @(posedge clk); #1;
        chk("R2 pre-reset route", 64'(out_route), 64'h1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 reset route", 64'(out_route), 64'd0);
        chk("R1 reset paddr", out_paddr, 64'd0);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        idle_inputs();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule